// File: doc/BRIEF.md
# Table-Driven Convolutional Encoder

This block is a rate-1/2, nonsystematic, feedforward convolutional encoder. It does not use a modulo-2 adder tree. It looks up both coded bits of each input bit in a small rewritable table. A shift register keeps the last K−1 accepted input bits. The incoming bit and that stored history together form a K-bit table address. The upper address bits act as a row tag and the lower COL_W bits act as a column tag.

The encoder is retargeted to another generator pair of the same constraint length by rewriting the table through a one-entry-per-clock write port. Nothing else in the datapath changes. The host builds the table image from the polynomials, for example 133/171 or 117/155 octal at K = 7, or 753/561 octal at K = 9.

Each coded pair is delivered as a registered 2-bit word one clock after its input bit. The pair can also be delivered as a serial stream of one bit per clock.

Top module: `lut_conv_encoder`

## Requirements
- R1: A bit accepted with `inValid` high produces `outValid` high on the next clock, and only then. A cycle with `inValid` low produces `outValid` low on the next clock.
- R2: The window address is {inBit, state}.
  - Bit K−1 of the address is the current input bit.
  - Bit K−2 is the most recent stored bit.
  - Bit 0 is the oldest stored bit.
  - `outCode` is the table entry at that address: bit 0 is C0 and bit 1 is C1.
  - If entry a holds {^(a & g1), ^(a & g0)}, then `outCode` equals the XOR convolution of the input stream with that generator pair, one cycle late.
- R3: The history register advances only on cycles with `inValid` high. The new bit enters at state bit K−2 and the oldest bit is dropped. Idle cycles between bits do not change the coded sequence.
- R4: A synchronous active-high `rst` does three things:
  - It clears the history to zero.
  - It holds `outValid` and `serValid` low.
  - It makes any `inValid` asserted during reset have no effect.
- R5: A write with `wrEn` high stores `wrData` at `wrAddr` on the clock edge. An encode in the same cycle that reads that address gets the previous contents.
- R6: After the whole table is rewritten with a different generator pair, the output follows the new pair. No other reconfiguration is needed.
- R7: `outCode` holds its last value on cycles with no accepted input.
- R8: In each `outValid` cycle, `serBit` carries C0 and `serValid` is high. On the following cycle, if no new word arrives, `serBit` carries C1 of the same word with `serValid` high. After that, `serValid` falls.
- R9: If a new word arrives in the cycle meant for the previous word's C1, the serial output shows the new word's C0 instead. A complete serial stream therefore needs at least one idle cycle between accepted bits.
- R10: Reset does not alter the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inBit` |
| inBit | input | 1 | Information bit to encode |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | K | Table entry address, {input bit, history} |
| wrData | input | 2 | Entry value, bit 0 = C0, bit 1 = C1 |
| outValid | output | 1 | Parallel coded word valid |
| outCode | output | 2 | Coded pair, bit 0 = C0, bit 1 = C1 |
| serValid | output | 1 | Serial coded bit valid |
| serBit | output | 1 | Serial coded bit, C0 first then C1 |

## Verification
The properties assume that `rst`, `inValid` and `inBit` are always driven to known levels. They also assume that a reset lasts at least one clock, so that the history-clear and output-quiet checks have a completed reset edge to look back on.

Table writes are expected only while the encoder is idle, except for one deliberate same-cycle collision used to check read-before-write ordering. The stimulus loads whole tables with `inValid` low and confines the collision to a single directed task. The serial checks space accepted bits by at least one idle cycle, except in the one task that exercises the overlap case.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int CODE_W = 2;

  typedef struct packed {
    logic clear;
    logic advance;
    logic serSecond;
  } enc_strobe_t;
endpackage

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
  import conv_enc_pkg::*;
#(
  parameter bit SERIAL_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output enc_strobe_t strobes,
  output logic        outValid,
  output logic        serValid
);
  logic validQ;
  logic serSecondW;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign outValid = validQ;

  generate
    if (SERIAL_OUT) begin : g_ser
      logic pendQ;
      always_ff @(posedge clk) begin
        if (rst) pendQ <= 1'b0;
        else     pendQ <= validQ;
      end
      // a fresh word takes the serial slot over a pending second bit
      assign serSecondW = pendQ & ~validQ;
      assign serValid   = validQ | pendQ;

      // R8: a lone second serial bit is always preceded by a word
      p_ser_origin_r8: assert property (@(posedge clk) disable iff (rst)
        (serValid && !outValid) |-> $past(outValid));
    end else begin : g_noser
      assign serSecondW = 1'b0;
      assign serValid   = 1'b0;
    end
  endgenerate

  assign strobes = '{clear: rst, advance: inValid & ~rst, serSecond: serSecondW};

  // R1: one-cycle word latency
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R4: outputs quiet after a reset edge
  p_reset_quiet_r4: assert property (@(posedge clk)
    rst |=> (!outValid && !serValid));
endmodule

// File: rtl/conv_enc_datapath.sv
module conv_enc_datapath
  import conv_enc_pkg::*;
#(
  parameter int K          = 7,
  parameter int COL_W      = 2,
  parameter bit SERIAL_OUT = 1'b1
) (
  input  logic              clk,
  input  enc_strobe_t       strobes,
  input  logic              inBit,
  input  logic              wrEn,
  input  logic [K-1:0]      wrAddr,
  input  logic [CODE_W-1:0] wrData,
  output logic [CODE_W-1:0] outCode,
  output logic              serBit
);
  localparam int ST_W     = K - 1;
  localparam int ROW_W    = K - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int ROW_BITS = CODE_W * COLS;

  logic [ST_W-1:0]          stateQ;
  logic [CODE_W-1:0]        codeQ;
  logic [K-1:0]             addr;
  logic [ROW_W-1:0]         rowTag;
  logic [COL_W-1:0]         colTag;
  logic [ROW_W-1:0]         wrRow;
  logic [COL_W-1:0]         wrCol;
  logic [ROWS*ROW_BITS-1:0] rowsFlat;
  logic [ROW_BITS-1:0]      selRow;
  logic [CODE_W-1:0]        entry;

  assign addr   = {inBit, stateQ};
  assign rowTag = addr[K-1:COL_W];
  assign colTag = addr[COL_W-1:0];
  assign wrRow  = wrAddr[K-1:COL_W];
  assign wrCol  = wrAddr[COL_W-1:0];

  // one storage row per row tag; each row holds every column entry
  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [ROW_BITS-1:0] rowQ;
      always_ff @(posedge clk) begin
        if (wrEn && (wrRow == ROW_W'(r)))
          rowQ[int'(wrCol)*CODE_W +: CODE_W] <= wrData;
      end
      assign rowsFlat[r*ROW_BITS +: ROW_BITS] = rowQ;
    end
  endgenerate

  // row select, then column select
  assign selRow = rowsFlat[int'(rowTag)*ROW_BITS +: ROW_BITS];
  assign entry  = selRow[int'(colTag)*CODE_W +: CODE_W];

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      stateQ <= '0;
      codeQ  <= '0;
    end else if (strobes.advance) begin
      stateQ <= {inBit, stateQ[ST_W-1:1]};
      codeQ  <= entry;
    end
  end

  assign outCode = codeQ;

  generate
    if (SERIAL_OUT) begin : g_ser
      assign serBit = strobes.serSecond ? codeQ[1] : codeQ[0];
    end else begin : g_noser
      assign serBit = 1'b0;
    end
  endgenerate

  // R4: history cleared by reset
  p_state_clear_r4: assert property (@(posedge clk)
    strobes.clear |=> (stateQ == '0));
  // R3: history moves only on accepted bits, newest at the top
  p_state_hold_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(stateQ));
  p_state_shift_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.advance |=> (stateQ[ST_W-1] == $past(inBit)));
  // R7: coded word held while idle
  p_code_hold_r7: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(codeQ));
endmodule

// File: rtl/lut_conv_encoder.sv
module lut_conv_encoder
  import conv_enc_pkg::*;
#(
  parameter int K          = 7,
  parameter int COL_W      = 2,
  parameter bit SERIAL_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inBit,
  input  logic         wrEn,
  input  logic [K-1:0] wrAddr,
  input  logic [1:0]   wrData,
  output logic         outValid,
  output logic [1:0]   outCode,
  output logic         serValid,
  output logic         serBit
);
  enc_strobe_t strobes;

  conv_enc_ctrl #(.SERIAL_OUT(SERIAL_OUT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid),
    .serValid (serValid)
  );

  conv_enc_datapath #(.K(K), .COL_W(COL_W), .SERIAL_OUT(SERIAL_OUT)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .inBit   (inBit),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .outCode (outCode),
    .serBit  (serBit)
  );
endmodule

// File: tb/lut_conv_encoder_bench.sv
module lut_conv_encoder_bench;
  localparam int K = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inBit = 1'b0;
  logic         wrEn = 1'b0;
  logic [K-1:0] wrAddr = '0;
  logic [1:0]   wrData = '0;
  logic         outValid;
  logic [1:0]   outCode;
  logic         serValid;
  logic         serBit;

  int checks = 0;
  int fails  = 0;
  logic [K-1:0]  g0Cur, g1Cur;
  logic [K-2:0]  refState = '0;
  logic [1:0]    lastCode = '0;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  lut_conv_encoder u_lut_conv_encoder (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outCode(outCode),
    .serValid(serValid), .serBit(serBit)
  );

  function automatic logic [1:0] refCode(input logic [K-1:0] w,
                                         input logic [K-1:0] ga,
                                         input logic [K-1:0] gb);
    return {^(w & gb), ^(w & ga)};
  endfunction

  function automatic logic nextBit();
    logic b;
    b = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    return b;
  endfunction

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic loadTable(input logic [K-1:0] ga, input logic [K-1:0] gb);
    for (int a = 0; a < (1 << K); a++) begin
      @(negedge clk);
      inValid = 1'b0;
      wrEn    = 1'b1;
      wrAddr  = K'(a);
      wrData  = refCode(K'(a), ga, gb);
    end
    @(negedge clk);
    wrEn  = 1'b0;
    g0Cur = ga;
    g1Cur = gb;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; inBit = 1'b1; wrEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(!outValid, "R4 outValid low in reset", outValid, 0);
    check(!serValid, "R4 serValid low in reset", serValid, 0);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    refState = '0;
    lastCode = '0;
  endtask

  task automatic encodeBit(input logic b, input string tag);
    logic [1:0] e;
    @(negedge clk);
    wrEn = 1'b0; inValid = 1'b1; inBit = b;
    e = refCode({b, refState}, g0Cur, g1Cur);
    refState = {b, refState[K-2:1]};
    @(posedge clk);
    #1;
    check(outValid, "R1 outValid one cycle after input", outValid, 1);
    check(outCode == e, tag, outCode, e);
    lastCode = e;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0; inBit = ~inBit;
    @(posedge clk);
    #1;
    check(!outValid, "R1 outValid low after idle", outValid, 0);
    check(outCode == lastCode, "R7 outCode held while idle", outCode, lastCode);
  endtask

  task automatic tImpulse();
    doReset();
    encodeBit(1'b1, "R10 table kept over reset, impulse tap");
    for (int i = 0; i < K - 1; i++) encodeBit(1'b0, "R2 impulse response tap");
  endtask

  task automatic tStream();
    for (int i = 0; i < 48; i++) encodeBit(nextBit(), "R2 random stream");
  endtask

  task automatic tPatterns();
    for (int i = 0; i < 10; i++) encodeBit(1'b1, "R2 all-ones run");
    for (int i = 0; i < 12; i++) encodeBit(i[0], "R2 alternating run");
  endtask

  task automatic tGaps();
    for (int i = 0; i < 16; i++) begin
      encodeBit(nextBit(), "R3 history kept across idle gaps");
      for (int j = 0; j <= (i % 3); j++) idleCycle();
    end
  endtask

  task automatic tSerial();
    doReset();
    for (int i = 0; i < 6; i++) begin
      encodeBit(nextBit(), "R2 serial-mode word");
      check(serValid && serBit == lastCode[0], "R8 first serial bit is C0", serBit, lastCode[0]);
      idleCycle();
      check(serValid && serBit == lastCode[1], "R8 second serial bit is C1", serBit, lastCode[1]);
      idleCycle();
      check(!serValid, "R8 serial idle after pair", serValid, 0);
    end
    encodeBit(1'b1, "R2 overlap word A");
    encodeBit(1'b0, "R2 overlap word B");
    check(serValid && serBit == lastCode[0], "R9 new word C0 takes slot", serBit, lastCode[0]);
    idleCycle();
    check(serValid && serBit == lastCode[1], "R9 new word C1 follows", serBit, lastCode[1]);
  endtask

  task automatic tCollision();
    doReset();
    @(negedge clk);
    inValid = 1'b1; inBit = 1'b0;
    wrEn = 1'b1; wrAddr = '0; wrData = 2'b11;
    @(posedge clk);
    #1;
    check(outCode == 2'b00, "R5 same-cycle encode reads old entry", outCode, 0);
    @(negedge clk);
    wrEn = 1'b0; inValid = 1'b0;
    doReset();
    @(negedge clk);
    inValid = 1'b1; inBit = 1'b0;
    @(posedge clk);
    #1;
    check(outCode == 2'b11, "R5 later encode reads new entry", outCode, 3);
    @(negedge clk);
    inValid = 1'b0; wrEn = 1'b1; wrAddr = '0; wrData = 2'b00;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tResetMid();
    for (int i = 0; i < 8; i++) encodeBit(1'b1, "R2 ones before reset");
    doReset();
    encodeBit(1'b0, "R4 history zero after reset");
    encodeBit(1'b1, "R4 first one after reset");
  endtask

  task automatic tReconfig();
    loadTable(7'o117, 7'o155);
    doReset();
    encodeBit(1'b1, "R6 impulse with new pair");
    for (int i = 0; i < 32; i++) encodeBit(nextBit(), "R6 stream with new pair");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!outValid, "R4 reset state outValid", outValid, 0);
    check(!serValid, "R4 reset state serValid", serValid, 0);
    check(outCode == 2'b00, "R4 reset state outCode", outCode, 0);
    @(negedge clk);
    rst = 1'b0;
    loadTable(7'o133, 7'o171);
    tImpulse();
    tStream();
    tPatterns();
    tGaps();
    tSerial();
    tCollision();
    tResetMid();
    tReconfig();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (R1 progress) actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule